// File: doc/BRIEF.md
# Chip-8 Variable and Index Transfer Unit

This block carries out the data-movement group of the Chip-8 instruction set in hardware. It holds the sixteen 8-bit variables V0..VF and the 12-bit index pointer I. A host front end hands it one already-fetched 16-bit opcode together with a one-cycle `start` strobe. The unit then executes the opcode and reports completion with a one-cycle `done` pulse.

The unit supports five kinds of operation:
- immediate loads into a variable;
- variable-to-variable copies;
- loads of the index pointer;
- two block operations that move V0..VX between the variables and a byte-wide single-port memory.

The block operations use one memory byte per clock. Memory reads are expected to return data one cycle after the address is presented. Any opcode outside this group is rejected in one cycle with `unsupported` raised, and it leaves all state untouched.

Opcode fields used throughout:
- bits [15:12]: group nibble
- bits [11:8]: X
- bits [7:4]: Y
- bits [3:0]: N
- bits [7:0]: NN

Top module: `chip8_ldst`

## Requirements
- R1: After reset, `busy`, `done`, `unsupported` and `mem_we` are low, I is 0 and every variable is 0. While idle, `mem_addr` presents the current value of I.
- R2: Opcode 6XNN (group 0x6) writes NN into VX and completes with `done` high in the cycle after the accepting edge, with `busy` low.
- R3: Opcode 8XY0 (group 0x8, N = 0) copies VY into VX and completes in one cycle.
- R4: Opcode 8XYN with N ≠ 0 completes in one cycle with `unsupported` high and changes no variable and not I.
- R5: Opcode AMMM (group 0xA) sets I to bits [11:0] of the opcode, which is the opcode with its top nibble cleared (AD08 gives 0x0D08). It completes in one cycle.
- R6: Opcode FX55 (group 0xF, low byte 0x55) writes V0, V1 … VX in ascending order, one byte per cycle with `mem_we` high, at addresses I, I+1 … I+X. It transfers exactly X+1 bytes, with X = 0 storing only V0 and X = F storing all sixteen. `done` follows in the cycle after the last write.
- R7: Opcode FX65 (group 0xF, low byte 0x65) presents addresses I … I+X on consecutive cycles with `mem_we` low, and loads the byte returned one cycle later into V0 … VX in order. `busy` stays high for one extra cycle after the last address, and `done` follows.
- R8: After FX55 or FX65, I equals its start value plus X+1, modulo 4096. Addresses step by one per transferred byte and wrap from 0xFFF to 0x000 with no range check.
- R9: `done` is a single-cycle pulse and is never high together with `busy`. `busy` is high from the cycle after a block operation is accepted until `done`.
- R10: A `start` pulse arriving while `busy` is high is ignored and has no effect on the variables or on I.
- R11: Any opcode whose group is not 0x6, 0x8, 0xA or 0xF, and any group-0xF opcode whose low byte is neither 0x55 nor 0x65, completes in one cycle with `done` and `unsupported` high and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Accept `opcode` on this edge when idle |
| opcode | input | 16 | Decoded opcode word |
| busy | output | 1 | A block transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| unsupported | output | 1 | Accompanies `done` when the opcode was rejected |
| mem_addr | output | 12 | Memory byte address; equals I |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid one cycle after its address |

## Verification
A wrong variable or index value stays hidden until a later block store sends it out. It then appears on `mem_wdata` or `mem_addr` in the very cycle of that byte's write. This is why the bench dumps all sixteen variables after each group of changes. A broken step counter or sequencing state shows up at once as an address that fails to step by one, a missing or extra write cycle, or a `done` pulse one cycle early or late. Each cycle of every operation is compared against a behavioural model.

// File: rtl/chip8_ldst_pkg.sv
package chip8_ldst_pkg;

    localparam int OPCODE_W = 16;
    localparam int FIELD_W  = 4;
    localparam int IMM_W    = 8;
    localparam int OPADDR_W = 12;

    typedef enum logic [2:0] {
        K_SETV,
        K_COPY,
        K_SETI,
        K_STORE,
        K_LOAD,
        K_REJECT
    } op_kind_e;

    typedef struct packed {
        op_kind_e              kind;
        logic [FIELD_W-1:0]    x;
        logic [FIELD_W-1:0]    y;
        logic [IMM_W-1:0]      imm;
        logic [OPADDR_W-1:0]   addr;
    } op_dec_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_STORE,
        SQ_LOAD,
        SQ_DRAIN
    } seq_state_e;

    function automatic op_dec_t decode_op(input logic [OPCODE_W-1:0] w);
        op_dec_t d;
        d.x    = w[11:8];
        d.y    = w[7:4];
        d.imm  = w[7:0];
        d.addr = w[11:0];
        unique case (w[15:12])
            4'h6:    d.kind = K_SETV;
            4'h8:    d.kind = (w[3:0] == 4'h0) ? K_COPY : K_REJECT;
            4'hA:    d.kind = K_SETI;
            4'hF: begin
                if (w[7:0] == 8'h55)      d.kind = K_STORE;
                else if (w[7:0] == 8'h65) d.kind = K_LOAD;
                else                      d.kind = K_REJECT;
            end
            default: d.kind = K_REJECT;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/chip8_ldst_decode.sv
module chip8_ldst_decode
    import chip8_ldst_pkg::*;
(
    input  logic [OPCODE_W-1:0] opcode,
    output op_dec_t             dec
);
    always_comb dec = decode_op(opcode);
endmodule

// File: rtl/chip8_ldst_vregs.sv
module chip8_ldst_vregs #(
    parameter int DATA_W = 8,
    parameter int NUM_V  = 16,
    localparam int IDX_W = $clog2(NUM_V)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] cells [NUM_V];

    for (genvar g = 0; g < NUM_V; g++) begin : g_cell
        logic [DATA_W-1:0] cell_q;
        always_ff @(posedge clk) begin
            if (rst)
                cell_q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                cell_q <= wr_data;
        end
        assign cells[g] = cell_q;
    end

    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/chip8_ldst_seq.sv
module chip8_ldst_seq
    import chip8_ldst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NUM_V  = 16,
    parameter int ADDR_W = 12,
    localparam int IDX_W = $clog2(NUM_V)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  op_dec_t           dec,
    input  logic [DATA_W-1:0] v_rd_data,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [IDX_W-1:0]  v_rd_idx,
    output logic              v_wr_en,
    output logic [IDX_W-1:0]  v_wr_idx,
    output logic [DATA_W-1:0] v_wr_data,
    output logic              busy,
    output logic              done,
    output logic              unsupported,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata
);
    seq_state_e        state_q;
    logic [IDX_W-1:0]  step_q;
    logic [IDX_W-1:0]  last_q;
    logic [ADDR_W-1:0] index_q;
    logic              pend_q;
    logic [IDX_W-1:0]  pend_idx_q;
    logic              done_q;
    logic              unsup_q;
    logic              accept;

    assign accept = start && (state_q == SQ_IDLE);

    // register-file access: the single read port serves the copy and the store
    always_comb begin
        v_rd_idx  = (state_q == SQ_STORE) ? step_q : IDX_W'(dec.y);
        v_wr_en   = 1'b0;
        v_wr_idx  = IDX_W'(dec.x);
        v_wr_data = DATA_W'(dec.imm);
        if (pend_q) begin
            v_wr_en   = 1'b1;
            v_wr_idx  = pend_idx_q;
            v_wr_data = mem_rdata;
        end else if (accept && dec.kind == K_SETV) begin
            v_wr_en   = 1'b1;
        end else if (accept && dec.kind == K_COPY) begin
            v_wr_en   = 1'b1;
            v_wr_data = v_rd_data;
        end
    end

    assign busy        = (state_q != SQ_IDLE);
    assign done        = done_q;
    assign unsupported = unsup_q;
    assign mem_addr    = index_q;
    assign mem_we      = (state_q == SQ_STORE);
    assign mem_wdata   = v_rd_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_IDLE;
            step_q     <= '0;
            last_q     <= '0;
            index_q    <= '0;
            pend_q     <= 1'b0;
            pend_idx_q <= '0;
            done_q     <= 1'b0;
            unsup_q    <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            unsup_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        step_q <= '0;
                        last_q <= IDX_W'(dec.x);
                        unique case (dec.kind)
                            K_SETV, K_COPY: done_q <= 1'b1;
                            K_SETI: begin
                                index_q <= ADDR_W'(dec.addr);
                                done_q  <= 1'b1;
                            end
                            K_STORE: state_q <= SQ_STORE;
                            K_LOAD:  state_q <= SQ_LOAD;
                            default: begin
                                done_q  <= 1'b1;
                                unsup_q <= 1'b1;
                            end
                        endcase
                    end
                end
                SQ_STORE: begin
                    index_q <= index_q + ADDR_W'(1);
                    step_q  <= step_q + IDX_W'(1);
                    if (step_q == last_q) begin
                        state_q <= SQ_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                SQ_LOAD: begin
                    index_q    <= index_q + ADDR_W'(1);
                    step_q     <= step_q + IDX_W'(1);
                    pend_q     <= 1'b1;
                    pend_idx_q <= step_q;
                    if (step_q == last_q)
                        state_q <= SQ_DRAIN;
                end
                SQ_DRAIN: begin
                    pend_q  <= 1'b0;
                    state_q <= SQ_IDLE;
                    done_q  <= 1'b1;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/chip8_ldst.sv
module chip8_ldst
    import chip8_ldst_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NUM_V  = 16,
    parameter int ADDR_W = 12,
    localparam int IDX_W = $clog2(NUM_V)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [OPCODE_W-1:0] opcode,
    output logic                busy,
    output logic                done,
    output logic                unsupported,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_we,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata
);
    op_dec_t           dec;
    logic [IDX_W-1:0]  v_rd_idx;
    logic [DATA_W-1:0] v_rd_data;
    logic              v_wr_en;
    logic [IDX_W-1:0]  v_wr_idx;
    logic [DATA_W-1:0] v_wr_data;

    chip8_ldst_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    chip8_ldst_vregs #(.DATA_W(DATA_W), .NUM_V(NUM_V)) u_vregs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (v_wr_en),
        .wr_idx  (v_wr_idx),
        .wr_data (v_wr_data),
        .rd_idx  (v_rd_idx),
        .rd_data (v_rd_data)
    );

    chip8_ldst_seq #(.DATA_W(DATA_W), .NUM_V(NUM_V), .ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .dec         (dec),
        .v_rd_data   (v_rd_data),
        .mem_rdata   (mem_rdata),
        .v_rd_idx    (v_rd_idx),
        .v_wr_en     (v_wr_en),
        .v_wr_idx    (v_wr_idx),
        .v_wr_data   (v_wr_data),
        .busy        (busy),
        .done        (done),
        .unsupported (unsupported),
        .mem_addr    (mem_addr),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata)
    );
endmodule

// File: rtl/chip8_ldst_chk.sv
module chip8_ldst_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              unsupported,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    // R1
    rst_quiet_chk: assert property (@(posedge clk)
        rst |=> (!busy && !done && !mem_we && !unsupported));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    write_busy_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    // R11
    reject_done_chk: assert property (@(posedge clk) disable iff (rst)
        unsupported |-> done);

    // R8
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));
endmodule

bind chip8_ldst chip8_ldst_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .done        (done),
    .unsupported (unsupported),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr)
);

// File: tb/tb_chip8_ldst.sv
`timescale 1ns/1ps
module tb_chip8_ldst;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] opcode = 16'h0000;
    logic        busy, done, unsupported, mem_we;
    logic [11:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem [4096];

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    int vm [16];
    int im;
    int mm [int];

    always #2.5 clk = ~clk;

    chip8_ldst dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .busy(busy), .done(done), .unsupported(unsupported),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // byte memory with one cycle of read latency
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_reject(input logic [15:0] w);
        case (w[15:12])
            4'h6, 4'hA: return 1'b0;
            4'h8:       return w[3:0] != 4'h0;
            4'hF:       return !(w[7:0] == 8'h55 || w[7:0] == 8'h65);
            default:    return 1'b1;
        endcase
    endfunction

    task automatic issue(input logic [15:0] op);
        @(negedge clk);
        start  = 1'b1;
        opcode = op;
        @(negedge clk);
        start  = 1'b0;
    endtask

    task automatic single(input logic [15:0] op, input string req);
        bit bad;
        bad = model_reject(op);
        issue(op);
        check(req, "done", int'(done), 1);
        check(req, "unsupported", int'(unsupported), int'(bad));
        check(req, "busy", int'(busy), 0);
        check(req, "mem_we", int'(mem_we), 0);
        if (!bad) begin
            case (op[15:12])
                4'h6: vm[op[11:8]] = int'(op[7:0]);
                4'h8: vm[op[11:8]] = vm[op[7:4]];
                4'hA: im = int'(op[11:0]);
                default: ;
            endcase
        end
        @(negedge clk);
        check("R9", "done pulse end", int'(done), 0);
        check(req, "index shown idle", int'(mem_addr), im);
    endtask

    task automatic store(input int x, input string req, input bit intrude);
        issue(16'hF055 | 16'(x << 8));
        for (int k = 0; k <= x; k++) begin
            check(req, "busy in store", int'(busy), 1);
            check(req, "mem_we", int'(mem_we), 1);
            check(req, "addr", int'(mem_addr), (im + k) & 'hFFF);
            check(req, "wdata", int'(mem_wdata), vm[k]);
            mm[(im + k) & 'hFFF] = vm[k];
            if (intrude && k == 0) begin
                start  = 1'b1;
                opcode = 16'h60AA;
            end else begin
                start  = 1'b0;
            end
            @(negedge clk);
        end
        im = (im + x + 1) & 'hFFF;
        check("R9", "store done", int'(done), 1);
        check("R9", "busy after store", int'(busy), 0);
        check(req, "mem_we after store", int'(mem_we), 0);
        check("R8", "index after store", int'(mem_addr), im);
        @(negedge clk);
        check("R9", "done pulse end", int'(done), 0);
    endtask

    task automatic load(input int x, input string req);
        issue(16'hF065 | 16'(x << 8));
        for (int k = 0; k <= x; k++) begin
            check(req, "busy in load", int'(busy), 1);
            check(req, "mem_we low", int'(mem_we), 0);
            check(req, "addr", int'(mem_addr), (im + k) & 'hFFF);
            @(negedge clk);
        end
        check(req, "drain busy", int'(busy), 1);
        check(req, "drain done low", int'(done), 0);
        @(negedge clk);
        check(req, "load done", int'(done), 1);
        check(req, "busy after load", int'(busy), 0);
        for (int k = 0; k <= x; k++) vm[k] = mm[(im + k) & 'hFFF];
        im = (im + x + 1) & 'hFFF;
        check("R8", "index after load", int'(mem_addr), im);
        @(negedge clk);
        check("R9", "done pulse end", int'(done), 0);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) vm[k] = 0;
        im = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "busy", int'(busy), 0);
        check("R1", "done", int'(done), 0);
        check("R1", "unsupported", int'(unsupported), 0);
        check("R1", "mem_we", int'(mem_we), 0);
        check("R1", "index", int'(mem_addr), 0);
        store(15, "R1", 1'b0);

        // R2 immediate loads of distinct values
        for (int k = 0; k < 16; k++)
            single(16'h6000 | 16'(k << 8) | 16'((k * 37 + 5) & 255), "R2");
        // R3 copies
        single(16'h8150, "R3");
        single(16'h8E30, "R3");
        // R4 rejected arithmetic variants
        single(16'h8A21, "R4");
        single(16'h832F, "R4");
        // R5 index load with the top nibble stripped
        single(16'hAD08, "R5");
        store(15, "R6", 1'b0);
        store(0, "R6", 1'b0);

        // R11 other opcodes
        single(16'h1234, "R11");
        single(16'hF107, "R11");
        single(16'hE09E, "R11");
        single(16'h0000, "R11");
        single(16'hA100, "R5");
        store(15, "R11", 1'b0);

        // R10 start during a transfer
        store(15, "R10", 1'b1);
        store(15, "R10", 1'b0);

        // R8 wrap past the top of the address space
        single(16'hAFFE, "R8");
        store(3, "R8", 1'b0);

        // R7 overwrite then restore from memory, across the wrap
        for (int k = 0; k < 4; k++)
            single(16'h6000 | 16'(k << 8) | 16'(8'hC0 + k), "R2");
        single(16'hAFFE, "R5");
        load(3, "R7");
        store(15, "R7", 1'b0);
        single(16'hAD08, "R5");
        single(16'h6000, "R2");
        load(0, "R7");
        single(16'hA200, "R5");
        store(15, "R7", 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule